// File: doc/BRIEF.md
# Dual Time-of-Day Alarm Interrupt Unit

This unit sits beside the timekeeping counter chain of a real-time clock. It holds two independent alarm sets, each made of four byte-wide fields (second, minute, hour, day). The most significant bit of every field is a "don't care" flag that drops the field from the comparison. On each one-second strobe from the counter chain, while the oscillator is running, each set is compared against the current time. A set whose unmasked fields all agree raises its pending flag.

A control register selects whether the oscillator runs and whether writes are protected. It also chooses how the two pending flags reach the two active-low interrupt pins, and gates each flag with its own enable. Software reaches the registers over a byte-wide port. Bit 7 of the address separates writes from reads: a write targets the read address with 0x80 added. Reading or writing an alarm set acknowledges that set's flag.

Each alarm set tracks its pending flag with a two-state machine. FLAG_IDLE moves to FLAG_PEND on a strobe that matches while the oscillator runs (transition "match"). FLAG_PEND returns to FLAG_IDLE when that set is read or written in a cycle without a new match (transition "acknowledge"). A match in the same cycle as an acknowledge keeps the flag pending.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the control register reads 0xC0 (oscillator halted, writes protected, routing and enables 0). The status register reads 0x00, both interrupt pins are high, and `osc_halt` is 1.
- R2: A field whose bit 7 is 1 is left out of its set's comparison. This gives five repeat modes: every second, on a second match, on a minute+second match, on an hour+minute+second match, and on a full day+hour+minute+second match. Fields compare their bits 6:0 against the time input.
- R3: On a `tick_sec` cycle with the oscillator running, a set whose unmasked fields all match enters FLAG_PEND. The status register at read address 0x10 shows the alarm 0 flag at bit 0 and the alarm 1 flag at bit 1.
- R4: While the halt bit (control bit 7) is 1, `tick_sec` is ignored and no flag becomes pending. `osc_halt` mirrors the halt bit.
- R5: While the protect bit (control bit 6) is 1, every write is discarded, including writes to alarm fields and to control bits 7, 2, 1 and 0. A write to the control register still loads the protect bit from write data bit 6. A discarded write does not acknowledge a flag.
- R6: With the routing bit (control bit 2) at 1, `irq0_n` is low exactly while the alarm 0 flag is pending with enable 0 (control bit 0) set. `irq1_n` is low exactly while the alarm 1 flag is pending with enable 1 (control bit 1) set.
- R7: With the routing bit at 0, `irq0_n` is low while either enabled flag is pending, and `irq1_n` stays high.
- R8: A pending flag whose enable bit is 0 drives no pin, yet it still shows in the status register.
- R9: A read or an accepted write to any field of an alarm set returns that set's flag to FLAG_IDLE. Accesses to the other set, to control or to status leave it pending.
- R10: Alarm 0 fields are read at 0x07 to 0x0A and written at 0x87 to 0x8A, in the order second, minute, hour, day. Alarm 1 uses 0x0B to 0x0E and 0x8B to 0x8E in the same order. Control is read at 0x0F and written at 0x8F, and its bits 5 to 3 always read 0. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address; bit 7 set marks a write address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acknowledges alarm flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tick_sec | input | 1 | One-second strobe from the counter chain |
| cur_sec | input | 7 | Current seconds |
| cur_min | input | 7 | Current minutes |
| cur_hour | input | 7 | Current hours |
| cur_day | input | 7 | Current day |
| osc_halt | output | 1 | Oscillator stop request to the counter chain |
| irq0_n | output | 1 | Interrupt 0, active low |
| irq1_n | output | 1 | Interrupt 1, active low |

## Verification
`reg_rdata` follows `reg_addr` in the same cycle, so the bench compares it a short delay after driving the address and before the clock edge that performs the acknowledge. Writes, strobes and acknowledges take effect at the next rising edge. The interrupt pins and `osc_halt` decode registered state without another register, so they are due in the cycle right after that edge. The bench drives every stimulus on a falling edge and compares the pins on the following falling edge, after exactly one rising edge. Its model updates at that same point.

// File: rtl/rtc_alarm_pkg.sv
`timescale 1ns/1ps
package rtc_alarm_pkg;
    localparam logic [7:0] WR_FLAG = 8'h80;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_PEND
    } flag_state_t;

    typedef struct packed {
        logic halt;
        logic prot;
        logic route;
        logic en1;
        logic en0;
    } ctrl_t;
endpackage

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match #(
    parameter int NF = 4,
    parameter int FW = 8
) (
    input  logic [NF-1:0][FW-1:0] alarm_regs,
    input  logic [NF-1:0][FW-2:0] now,
    output logic                  hit
);
    logic [NF-1:0] fld_ok;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        assign fld_ok[i] = alarm_regs[i][FW-1] || (alarm_regs[i][FW-2:0] == now[i]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/rtc_alarm_unit.sv
`timescale 1ns/1ps
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter logic [7:0] BASE = 8'h07,
    parameter int         NF   = 4,
    parameter int         FW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic [FW-1:0]         wdata,
    input  logic                  rd,
    input  logic                  wr_en,
    input  logic                  tick_ok,
    input  logic [NF-1:0][FW-2:0] now,
    output logic [NF-1:0][FW-1:0] regs,
    output logic                  flag
);
    localparam logic [7:0] RD_LAST  = BASE + 8'(NF - 1);
    localparam logic [7:0] WR_FIRST = BASE | WR_FLAG;
    localparam logic [7:0] WR_LAST  = RD_LAST | WR_FLAG;

    logic        rd_hit, wr_hit, access, hit, tick_hit;
    flag_state_t state_q, state_d;

    assign rd_hit   = rd && (addr >= BASE) && (addr <= RD_LAST);
    assign wr_hit   = wr_en && (addr >= WR_FIRST) && (addr <= WR_LAST);
    assign access   = rd_hit || wr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (wr_en && (addr == WR_FIRST + 8'(i))) regs[i] <= wdata;
            end
        end
    end

    rtc_alarm_match #(.NF(NF), .FW(FW)) u_match (
        .alarm_regs(regs),
        .now       (now),
        .hit       (hit)
    );

    assign tick_hit = tick_ok && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (tick_hit)            state_d = FLAG_PEND;
            FLAG_PEND: if (access && !tick_hit) state_d = FLAG_IDLE;
            default:                            state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_PEND);
    end

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_ok && hit) |=> flag);

    assert_flag_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !(tick_ok && hit)) |=> !flag);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !access) |=> flag);
endmodule

// File: rtl/rtc_alarm_ctrl.sv
`timescale 1ns/1ps
module rtc_alarm_ctrl
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '{halt: 1'b1, prot: 1'b1, route: 1'b0, en1: 1'b0, en0: 1'b0};
        end else if (wr) begin
            if (ctrl.prot) begin
                ctrl.prot <= wdata[6];
            end else begin
                ctrl <= '{halt: wdata[7], prot: wdata[6], route: wdata[2],
                          en1: wdata[1], en0: wdata[0]};
            end
        end
    end

    assert_prot_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl.prot) |=> ($stable(ctrl.halt) && $stable(ctrl.route) &&
                               $stable(ctrl.en1) && $stable(ctrl.en0)));

    assert_prot_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[6]) |=> !ctrl.prot);
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int         FIELD_W    = 8,
    parameter int         NUM_FIELDS = 4,
    parameter logic [7:0] A0_BASE    = 8'h07,
    parameter logic [7:0] A1_BASE    = 8'h0B,
    parameter logic [7:0] CTRL_RD    = 8'h0F,
    parameter logic [7:0] STAT_RD    = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [FIELD_W-1:0] reg_wdata,
    output logic [FIELD_W-1:0] reg_rdata,
    input  logic               tick_sec,
    input  logic [FIELD_W-2:0] cur_sec,
    input  logic [FIELD_W-2:0] cur_min,
    input  logic [FIELD_W-2:0] cur_hour,
    input  logic [FIELD_W-2:0] cur_day,
    output logic               osc_halt,
    output logic               irq0_n,
    output logic               irq1_n
);
    localparam int         IDX_W   = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;
    localparam logic [7:0] A0_LAST = A0_BASE + 8'(NUM_FIELDS - 1);
    localparam logic [7:0] A1_LAST = A1_BASE + 8'(NUM_FIELDS - 1);
    localparam logic [7:0] CTRL_WR = CTRL_RD | WR_FLAG;

    ctrl_t                             ctrl;
    logic                              wr_ok, tick_ok, ctrl_wr;
    logic [NUM_FIELDS-1:0][FIELD_W-2:0] now_v;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] a0_regs, a1_regs;
    logic                              flag0, flag1;
    logic [7:0]                        off0, off1;

    assign now_v   = {cur_day, cur_hour, cur_min, cur_sec};
    assign wr_ok   = reg_wr && !ctrl.prot;
    assign tick_ok = tick_sec && !ctrl.halt;
    assign ctrl_wr = reg_wr && (reg_addr == CTRL_WR);

    rtc_alarm_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (ctrl_wr),
        .wdata(reg_wdata),
        .ctrl (ctrl)
    );

    rtc_alarm_unit #(.BASE(A0_BASE), .NF(NUM_FIELDS), .FW(FIELD_W)) u_alarm0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rd     (reg_rd),
        .wr_en  (wr_ok),
        .tick_ok(tick_ok),
        .now    (now_v),
        .regs   (a0_regs),
        .flag   (flag0)
    );

    rtc_alarm_unit #(.BASE(A1_BASE), .NF(NUM_FIELDS), .FW(FIELD_W)) u_alarm1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rd     (reg_rd),
        .wr_en  (wr_ok),
        .tick_ok(tick_ok),
        .now    (now_v),
        .regs   (a1_regs),
        .flag   (flag1)
    );

    assign off0 = reg_addr - A0_BASE;
    assign off1 = reg_addr - A1_BASE;

    always_comb begin
        reg_rdata = '0;
        if ((reg_addr >= A0_BASE) && (reg_addr <= A0_LAST)) begin
            reg_rdata = a0_regs[off0[IDX_W-1:0]];
        end else if ((reg_addr >= A1_BASE) && (reg_addr <= A1_LAST)) begin
            reg_rdata = a1_regs[off1[IDX_W-1:0]];
        end else if (reg_addr == CTRL_RD) begin
            reg_rdata = {ctrl.halt, ctrl.prot, 3'b000, ctrl.route, ctrl.en1, ctrl.en0};
        end else if (reg_addr == STAT_RD) begin
            reg_rdata = {6'b0, flag1, flag0};
        end
    end

    always_comb begin
        osc_halt = ctrl.halt;
        irq0_n   = !((flag0 && ctrl.en0) || (!ctrl.route && flag1 && ctrl.en1));
        irq1_n   = !(ctrl.route && flag1 && ctrl.en1);
    end

    assert_irq1_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.route |-> irq1_n);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en0 && !ctrl.en1) |-> (irq0_n && irq1_n));

    assert_irq1_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq1_n |-> flag1);

    assert_halt_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag0) || $rose(flag1)) |-> !$past(ctrl.halt));

    assert_prot_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.prot && reg_wr) |=> ($stable(a0_regs) && $stable(a1_regs)));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
`timescale 1ns/1ps
module sim_rtc_alarm_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, tick_sec = 1'b0;
    logic [7:0] reg_rdata;
    logic [6:0] tm [0:3];
    logic       osc_halt, irq0_n, irq1_n;

    int ntot = 0;
    int nbad = 0;

    bit [7:0] m_al [0:1][0:3];
    bit       m_halt, m_prot, m_route, m_en1, m_en0;
    bit       m_f [0:1];

    always #10 clk = ~clk;

    rtc_alarm_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_sec(tick_sec), .cur_sec(tm[0]), .cur_min(tm[1]),
        .cur_hour(tm[2]), .cur_day(tm[3]), .osc_halt(osc_halt),
        .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_match(int s);
        for (int f = 0; f < 4; f++)
            if (!m_al[s][f][7] && (m_al[s][f][6:0] != tm[f])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (a >= 8'h07 && a <= 8'h0A) return m_al[0][a - 8'h07];
        if (a >= 8'h0B && a <= 8'h0E) return m_al[1][a - 8'h0B];
        if (a == 8'h0F) return {m_halt, m_prot, 3'b000, m_route, m_en1, m_en0};
        if (a == 8'h10) return {6'b0, m_f[1], m_f[0]};
        return 8'h00;
    endfunction

    function automatic logic exp_irq0_n();
        return !((m_f[0] && m_en0) || (!m_route && m_f[1] && m_en1));
    endfunction

    function automatic logic exp_irq1_n();
        return !(m_route && m_f[1] && m_en1);
    endfunction

    task automatic chk_out(string tag);
        chk(tag, "irq0_n", {7'b0, irq0_n}, {7'b0, exp_irq0_n()});
        chk(tag, "irq1_n", {7'b0, irq1_n}, {7'b0, exp_irq1_n()});
        chk(tag, "osc_halt", {7'b0, osc_halt}, {7'b0, m_halt});
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h8F) begin
            if (m_prot) m_prot = d[6];
            else {m_halt, m_prot, m_route, m_en1, m_en0} = {d[7], d[6], d[2], d[1], d[0]};
        end else if (!m_prot) begin
            if (a >= 8'h87 && a <= 8'h8A) begin m_al[0][a - 8'h87] = d; m_f[0] = 1'b0; end
            if (a >= 8'h8B && a <= 8'h8E) begin m_al[1][a - 8'h8B] = d; m_f[1] = 1'b0; end
        end
        chk_out(tag);
    endtask

    task automatic do_read(logic [7:0] a, string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2;
        chk(tag, "rdata", reg_rdata, exp_rd(a));
        @(negedge clk);
        reg_rd = 1'b0;
        if (a >= 8'h07 && a <= 8'h0A) m_f[0] = 1'b0;
        if (a >= 8'h0B && a <= 8'h0E) m_f[1] = 1'b0;
        chk_out(tag);
    endtask

    task automatic do_tick(logic [6:0] s, logic [6:0] mi, logic [6:0] h, logic [6:0] d, string tag);
        @(negedge clk);
        tm[0] = s; tm[1] = mi; tm[2] = h; tm[3] = d; tick_sec = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0;
        if (!m_halt) begin
            if (exp_match(0)) m_f[0] = 1'b1;
            if (exp_match(1)) m_f[1] = 1'b1;
        end
        chk_out(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        logic [6:0] t [0:3];
        void'($urandom(32'd31415));
        for (int f = 0; f < 4; f++) tm[f] = '0;
        m_halt = 1; m_prot = 1; m_route = 0; m_en1 = 0; m_en0 = 0;
        m_f[0] = 0; m_f[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk_out("R1");
        do_read(8'h0F, "R1");
        do_read(8'h10, "R1");

        // R5: protected writes discarded, protect bit still clearable
        do_write(8'h87, 8'h55, "R5");
        do_read(8'h07, "R5");
        do_write(8'h8F, 8'h07, "R5");
        do_read(8'h0F, "R5");

        // R4: halted oscillator ignores a matching strobe
        do_tick(7'h00, 7'h00, 7'h00, 7'h00, "R4");
        do_read(8'h10, "R4");

        // R10: control bits 5..3 read as zero, map check
        do_write(8'h8F, 8'h3F, "R10");
        do_read(8'h0F, "R10");
        do_read(8'h11, "R10");

        // R2: repeat modes on alarm 0; all enables on, separate pins
        do_write(8'h8F, 8'h07, "R6");
        do_write(8'h87, 8'h80, "R2");
        do_write(8'h88, 8'h80, "R2");
        do_write(8'h89, 8'h80, "R2");
        do_write(8'h8A, 8'h80, "R2");
        do_tick(7'h11, 7'h22, 7'h05, 7'h02, "R2");
        do_read(8'h10, "R3");
        do_read(8'h07, "R9");
        do_write(8'h87, 8'h15, "R2");
        do_tick(7'h14, 7'h00, 7'h00, 7'h00, "R2");
        do_tick(7'h15, 7'h33, 7'h00, 7'h00, "R2");
        do_read(8'h0B, "R9");
        do_read(8'h10, "R9");
        do_write(8'h8A, 8'h03, "R2");
        do_write(8'h88, 8'h30, "R2");
        do_write(8'h89, 8'h12, "R2");
        do_tick(7'h15, 7'h30, 7'h12, 7'h04, "R2");
        do_tick(7'h15, 7'h30, 7'h12, 7'h03, "R2");

        // R7 / R8: shared pin, then enables off
        do_write(8'h8B, 8'h80, "R7");
        do_write(8'h8C, 8'h80, "R7");
        do_write(8'h8D, 8'h80, "R7");
        do_write(8'h8E, 8'h80, "R7");
        do_write(8'h8F, 8'h03, "R7");
        do_tick(7'h01, 7'h01, 7'h01, 7'h01, "R7");
        do_write(8'h8F, 8'h00, "R8");
        do_read(8'h10, "R8");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 100);
            if (op < 40) begin
                int src;
                src = int'($urandom % 3);
                for (int f = 0; f < 4; f++) begin
                    if (src < 2 && ($urandom % 5) != 0) t[f] = m_al[src][f][6:0];
                    else t[f] = 7'($urandom);
                end
                do_tick(t[0], t[1], t[2], t[3], "R3");
            end else if (op < 65) begin
                logic [7:0] d;
                d = 8'($urandom);
                d[7] = (($urandom % 2) == 0);
                do_write(8'h87 + 8'($urandom % 8), d, "R2");
            end else if (op < 80) begin
                do_read(8'h07 + 8'($urandom % 8), "R9");
            end else if (op < 90) begin
                logic [7:0] d;
                d = 8'($urandom);
                d[7] = (($urandom % 4) == 0);
                d[6] = (($urandom % 8) == 0);
                do_write(8'h8F, d, "R5");
            end else begin
                do_read((($urandom % 2) == 0) ? 8'h10 : 8'h0F, "R10");
            end
        end

        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule